// File: doc/BRIEF.md
# Snooping Cache-Line Coherence State Controller

This block tracks the coherence state of a single cache line on a snooping bus. It takes three kinds of event. Processor requests are translated into the bus command that must be issued. Bus responses fix the line's new stable state. Snooped commands from other agents decide whether this line supplies data, whether it drives the shared signal, and what state the line moves to. Three parameters select the protocol flavour: one allows the Owned state, one allows the Exclusive state, and one makes writes to a Shared line use upgrade commands. Together they give the MSI, MESI, MOSI and MOESI variants, with or without upgrades.

One event is accepted per cycle. A snoop beats a response, and a response beats a request. Its effect shows one clock later as a registered state and a one-cycle action pulse. Any state/command pair that the selected protocol does not allow raises a one-cycle error pulse and leaves the state unchanged. Two banks of saturating counters, one for the request path and one for the snoop path, count accepted events per (state, command) pair. A combinational index-and-data port reads them.

Top module: `coh_line_ctrl`

## Requirements
- R1: Encodings used throughout: states Invalid=0, Shared=1, Owned=2, Exclusive=3, Modified=4. Commands: read=0, write=1, soft prefetch=2, hard prefetch=3, writeback=4, read-exclusive=5, upgrade=6, invalidate=7, write-invalidate=8, read response=9, read-exclusive response=10, upgrade response=11. During reset the line is Invalid, every output pulse is low and every counter reads zero.
- R2: An accepted request never changes the state. From Invalid, a read or either prefetch issues bus read (0), and a write issues read-exclusive (5). bus_cmd_vld pulses for one cycle, in the cycle after the strobe.
- R3: A write to a Shared line issues upgrade (6) when upgrades are enabled and read-exclusive (5) otherwise. A write to an Owned line behaves the same way when Owned is enabled.
- R4: A writeback request is legal in every state and issues writeback (4).
- R5: A read response from Invalid goes to Exclusive when Exclusive is enabled and rsp_shared is low, and goes to Shared otherwise. A read-exclusive response from Invalid goes to Modified. From Shared, or from Owned when Owned is enabled, the write-to-shared response goes to Modified. That response is the upgrade response (11) with upgrades enabled and the read-exclusive response (10) without.
- R6: Snoops on Invalid: read and read-exclusive are legal and leave the line Invalid, and so is upgrade when upgrades are enabled. Invalidate and write-invalidate leave it Invalid. Snoops on Shared: read stays Shared and asserts shared only when Exclusive is enabled. Read-exclusive, invalidate and write-invalidate go to Invalid, and so does upgrade when upgrades are enabled.
- R7: Snoops on Modified: read-exclusive supplies data and goes to Invalid. Read supplies data and goes to Owned, or to Shared when Owned is disabled. Invalidate and write-invalidate go to Invalid.
- R8: Snoops on Exclusive: read asserts shared and goes to Shared. Read-exclusive, invalidate and write-invalidate go to Invalid. Snoops on Owned: read supplies data and stays Owned. Read-exclusive supplies data and goes to Invalid. Upgrade, invalidate and write-invalidate go to Invalid.
- R9: An accepted pair not listed in R2 to R8 pulses proto_err for one cycle. The state is then unchanged and no bus command, supply or shared pulse appears.
- R10: If several strobes arrive in one cycle, only the snoop is taken, or else only the response. The losing strobes have no effect on the state, the outputs or the counters.
- R11: Each accepted request or snoop increments its own path's counter at (state before the event, command), legal or not. Counters saturate at all-ones. cnt_data shows the counter selected by cnt_sel_snp (1 = snoop bank), cnt_state and cnt_cmd in the same cycle.
- R12: With Owned disabled the line never reaches Owned, and with Exclusive disabled it never reaches Exclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Processor request strobe |
| req_cmd | input | 4 | Processor request command |
| rsp_vld | input | 1 | Bus response strobe |
| rsp_cmd | input | 4 | Bus response command |
| rsp_shared | input | 1 | Shared line sampled with the response |
| snp_vld | input | 1 | Snooped command strobe |
| snp_cmd | input | 4 | Snooped command |
| line_state | output | 3 | Current line state |
| bus_cmd_vld | output | 1 | One-cycle pulse: bus_cmd is to be issued |
| bus_cmd | output | 4 | Bus command for the last request |
| snp_supply | output | 1 | One-cycle pulse: line supplies data |
| snp_assert_shared | output | 1 | One-cycle pulse: drive the shared signal |
| proto_err | output | 1 | One-cycle pulse: illegal state/command pair |
| cnt_sel_snp | input | 1 | Counter bank select, 1 = snoop path |
| cnt_state | input | 3 | Counter state index |
| cnt_cmd | input | 4 | Counter command index |
| cnt_data | output | CNT_W | Selected counter value |

## Verification
The embedded properties check on every cycle that an error pulse comes with no other action and no state change. They also check that requests never move the state, that data is only supplied from Modified or Owned, that the state only moves after an accepted strobe, that disabled states are never entered and that counters never wrap. Whether each individual table entry holds the right next state and command can only be shown by the bench. It sweeps every reachable state, every command code on all three paths and both shared-line values, for a full-featured configuration and for a minimal one. Strobe priority and counter saturation likewise rest on directed scenarios.

// File: rtl/coh_pkg.sv
package coh_pkg;
   localparam int ST_W   = 3;
   localparam int CMD_W  = 4;
   localparam int NUM_ST = 5;
   localparam int NUM_CMD = 1 << CMD_W;

   localparam logic [ST_W-1:0] ST_I = 3'd0;
   localparam logic [ST_W-1:0] ST_S = 3'd1;
   localparam logic [ST_W-1:0] ST_O = 3'd2;
   localparam logic [ST_W-1:0] ST_E = 3'd3;
   localparam logic [ST_W-1:0] ST_M = 3'd4;

   localparam logic [CMD_W-1:0] C_RD     = 4'd0;
   localparam logic [CMD_W-1:0] C_WR     = 4'd1;
   localparam logic [CMD_W-1:0] C_SPF    = 4'd2;
   localparam logic [CMD_W-1:0] C_HPF    = 4'd3;
   localparam logic [CMD_W-1:0] C_WB     = 4'd4;
   localparam logic [CMD_W-1:0] C_RDX    = 4'd5;
   localparam logic [CMD_W-1:0] C_UPG    = 4'd6;
   localparam logic [CMD_W-1:0] C_INV    = 4'd7;
   localparam logic [CMD_W-1:0] C_WINV   = 4'd8;
   localparam logic [CMD_W-1:0] C_RDRSP  = 4'd9;
   localparam logic [CMD_W-1:0] C_RDXRSP = 4'd10;
   localparam logic [CMD_W-1:0] C_UPGRSP = 4'd11;

   typedef struct packed {
      logic             ok;
      logic [ST_W-1:0]  nst;
      logic             bvld;
      logic [CMD_W-1:0] bcmd;
      logic             sup;
      logic             shr;
   } act_t;
endpackage

// File: rtl/coh_req_map.sv
module coh_req_map
   import coh_pkg::*;
#(
   parameter bit HAS_OWNED = 1'b1,
   parameter bit USE_UPG   = 1'b1
) (
   input  logic [ST_W-1:0]  st,
   input  logic [CMD_W-1:0] cmd,
   output act_t             act
);
   logic [CMD_W-1:0] wr_sh_cmd;

   generate
      if (USE_UPG) begin : g_upg
         assign wr_sh_cmd = C_UPG;
      end else begin : g_rdx
         assign wr_sh_cmd = C_RDX;
      end
   endgenerate

   always_comb begin
      act      = '0;
      act.nst  = st;
      if (cmd == C_WB) begin
         act.ok   = 1'b1;
         act.bvld = 1'b1;
         act.bcmd = C_WB;
      end else if (st == ST_I) begin
         if (cmd == C_RD || cmd == C_SPF || cmd == C_HPF) begin
            act.ok   = 1'b1;
            act.bvld = 1'b1;
            act.bcmd = C_RD;
         end else if (cmd == C_WR) begin
            act.ok   = 1'b1;
            act.bvld = 1'b1;
            act.bcmd = C_RDX;
         end
      end else if ((st == ST_S || (HAS_OWNED && st == ST_O)) && cmd == C_WR) begin
         act.ok   = 1'b1;
         act.bvld = 1'b1;
         act.bcmd = wr_sh_cmd;
      end
   end
endmodule

// File: rtl/coh_rsp_map.sv
module coh_rsp_map
   import coh_pkg::*;
#(
   parameter bit HAS_OWNED = 1'b1,
   parameter bit HAS_EXCL  = 1'b1,
   parameter bit USE_UPG   = 1'b1
) (
   input  logic [ST_W-1:0]  st,
   input  logic [CMD_W-1:0] cmd,
   input  logic             shared,
   output act_t             act
);
   logic [ST_W-1:0]  fill_st;
   logic [CMD_W-1:0] ws_rsp;

   generate
      if (HAS_EXCL) begin : g_excl
         assign fill_st = shared ? ST_S : ST_E;
      end else begin : g_noexcl
         assign fill_st = ST_S;
      end
      if (USE_UPG) begin : g_upg
         assign ws_rsp = C_UPGRSP;
      end else begin : g_rdx
         assign ws_rsp = C_RDXRSP;
      end
   endgenerate

   always_comb begin
      act     = '0;
      act.nst = st;
      if (st == ST_I && cmd == C_RDRSP) begin
         act.ok  = 1'b1;
         act.nst = fill_st;
      end else if (st == ST_I && cmd == C_RDXRSP) begin
         act.ok  = 1'b1;
         act.nst = ST_M;
      end else if ((st == ST_S || (HAS_OWNED && st == ST_O)) && cmd == ws_rsp) begin
         act.ok  = 1'b1;
         act.nst = ST_M;
      end
   end
endmodule

// File: rtl/coh_snp_map.sv
module coh_snp_map
   import coh_pkg::*;
#(
   parameter bit HAS_OWNED = 1'b1,
   parameter bit HAS_EXCL  = 1'b1,
   parameter bit USE_UPG   = 1'b1
) (
   input  logic [ST_W-1:0]  st,
   input  logic [CMD_W-1:0] cmd,
   output act_t             act
);
   logic kill;
   assign kill = (cmd == C_INV) || (cmd == C_WINV);

   always_comb begin
      act     = '0;
      act.nst = st;
      unique case (st)
         ST_I: begin
            if (cmd == C_RD || cmd == C_RDX || (USE_UPG && cmd == C_UPG) || kill)
               act.ok = 1'b1;
         end
         ST_S: begin
            if (cmd == C_RD) begin
               act.ok  = 1'b1;
               act.shr = HAS_EXCL;
            end else if (cmd == C_RDX || (USE_UPG && cmd == C_UPG) || kill) begin
               act.ok  = 1'b1;
               act.nst = ST_I;
            end
         end
         ST_M: begin
            if (cmd == C_RDX) begin
               act.ok  = 1'b1;
               act.sup = 1'b1;
               act.nst = ST_I;
            end else if (cmd == C_RD) begin
               act.ok  = 1'b1;
               act.sup = 1'b1;
               act.nst = HAS_OWNED ? ST_O : ST_S;
            end else if (kill) begin
               act.ok  = 1'b1;
               act.nst = ST_I;
            end
         end
         ST_E: begin
            if (HAS_EXCL && cmd == C_RD) begin
               act.ok  = 1'b1;
               act.shr = 1'b1;
               act.nst = ST_S;
            end else if (HAS_EXCL && (cmd == C_RDX || kill)) begin
               act.ok  = 1'b1;
               act.nst = ST_I;
            end
         end
         ST_O: begin
            if (HAS_OWNED && cmd == C_RD) begin
               act.ok  = 1'b1;
               act.sup = 1'b1;
            end else if (HAS_OWNED && cmd == C_RDX) begin
               act.ok  = 1'b1;
               act.sup = 1'b1;
               act.nst = ST_I;
            end else if (HAS_OWNED && (cmd == C_UPG || kill)) begin
               act.ok  = 1'b1;
               act.nst = ST_I;
            end
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/coh_evt_cnt.sv
module coh_evt_cnt
   import coh_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic [ST_W-1:0]  st,
   input  logic [CMD_W-1:0] cmd,
   input  logic [ST_W-1:0]  rd_st,
   input  logic [CMD_W-1:0] rd_cmd,
   output logic [CNT_W-1:0] rd_data
);
   localparam int N_CNT = NUM_ST * NUM_CMD;

   logic [N_CNT*CNT_W-1:0] flat;

   generate
      for (genvar s = 0; s < NUM_ST; s++) begin : g_st
         for (genvar c = 0; c < NUM_CMD; c++) begin : g_cmd
            logic [CNT_W-1:0] q;
            logic             hit;
            assign hit = inc && (st == ST_W'(s)) && (cmd == CMD_W'(c));
            always_ff @(posedge clk) begin
               if (!rst_n)
                  q <= '0;
               else if (hit && !(&q))
                  q <= q + 1'b1;
            end
            assign flat[(s*NUM_CMD + c)*CNT_W +: CNT_W] = q;

            // R11
            cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (&$past(q)) |-> (&q));
         end
      end
   endgenerate

   always_comb begin
      rd_data = '0;
      if (int'(rd_st) < NUM_ST)
         rd_data = flat[(int'(rd_st)*NUM_CMD + int'(rd_cmd))*CNT_W +: CNT_W];
   end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
   import coh_pkg::*;
#(
   parameter bit HAS_OWNED = 1'b1,
   parameter bit HAS_EXCL  = 1'b1,
   parameter bit USE_UPG   = 1'b1,
   parameter int CNT_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [3:0]       req_cmd,
   input  logic             rsp_vld,
   input  logic [3:0]       rsp_cmd,
   input  logic             rsp_shared,
   input  logic             snp_vld,
   input  logic [3:0]       snp_cmd,
   output logic [2:0]       line_state,
   output logic             bus_cmd_vld,
   output logic [3:0]       bus_cmd,
   output logic             snp_supply,
   output logic             snp_assert_shared,
   output logic             proto_err,
   input  logic             cnt_sel_snp,
   input  logic [2:0]       cnt_state,
   input  logic [3:0]       cnt_cmd,
   output logic [CNT_W-1:0] cnt_data
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
         $error("coh_line_ctrl: CNT_W must lie in 2..32");
      end
   endgenerate

   logic [ST_W-1:0] state_q;
   logic            bvld_q, sup_q, shr_q, err_q;
   logic [CMD_W-1:0] bcmd_q;
   act_t a_req, a_rsp, a_snp, sel;
   logic take_snp, take_rsp, take_req, any_vld;

   coh_req_map #(.HAS_OWNED(HAS_OWNED), .USE_UPG(USE_UPG)) u_req (
      .st(state_q), .cmd(req_cmd), .act(a_req));
   coh_rsp_map #(.HAS_OWNED(HAS_OWNED), .HAS_EXCL(HAS_EXCL), .USE_UPG(USE_UPG)) u_rsp (
      .st(state_q), .cmd(rsp_cmd), .shared(rsp_shared), .act(a_rsp));
   coh_snp_map #(.HAS_OWNED(HAS_OWNED), .HAS_EXCL(HAS_EXCL), .USE_UPG(USE_UPG)) u_snp (
      .st(state_q), .cmd(snp_cmd), .act(a_snp));

   assign take_snp = snp_vld;
   assign take_rsp = rsp_vld && !snp_vld;
   assign take_req = req_vld && !snp_vld && !rsp_vld;
   assign any_vld  = snp_vld || rsp_vld || req_vld;
   assign sel      = take_snp ? a_snp : (take_rsp ? a_rsp : a_req);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_I;
         bvld_q  <= 1'b0;
         bcmd_q  <= '0;
         sup_q   <= 1'b0;
         shr_q   <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         bvld_q <= 1'b0;
         sup_q  <= 1'b0;
         shr_q  <= 1'b0;
         err_q  <= 1'b0;
         if (any_vld) begin
            if (sel.ok) begin
               state_q <= sel.nst;
               bvld_q  <= sel.bvld;
               sup_q   <= sel.sup;
               shr_q   <= sel.shr;
               if (sel.bvld)
                  bcmd_q <= sel.bcmd;
            end else begin
               err_q <= 1'b1;
            end
         end
      end
   end

   assign line_state        = state_q;
   assign bus_cmd_vld       = bvld_q;
   assign bus_cmd           = bcmd_q;
   assign snp_supply        = sup_q;
   assign snp_assert_shared = shr_q;
   assign proto_err         = err_q;

   logic [CNT_W-1:0] rd_req, rd_snp;

   coh_evt_cnt #(.CNT_W(CNT_W)) u_cnt_req (
      .clk(clk), .rst_n(rst_n), .inc(take_req), .st(state_q), .cmd(req_cmd),
      .rd_st(cnt_state), .rd_cmd(cnt_cmd), .rd_data(rd_req));
   coh_evt_cnt #(.CNT_W(CNT_W)) u_cnt_snp (
      .clk(clk), .rst_n(rst_n), .inc(take_snp), .st(state_q), .cmd(snp_cmd),
      .rd_st(cnt_state), .rd_cmd(cnt_cmd), .rd_data(rd_snp));

   assign cnt_data = cnt_sel_snp ? rd_snp : rd_req;

   // R9
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !(bvld_q || sup_q || shr_q));
   // R9
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (state_q == $past(state_q)));
   // R2
   req_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(take_req) |-> (state_q == $past(state_q)));
   // R7
   supply_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sup_q |-> ($past(state_q) == ST_M || $past(state_q) == ST_O));
   // R10
   move_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != $past(state_q)) |-> $past(any_vld));

   generate
      if (!HAS_OWNED) begin : g_no_o_chk
         // R12
         no_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
            state_q != ST_O);
      end
      if (!HAS_EXCL) begin : g_no_e_chk
         // R12
         no_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            state_q != ST_E);
      end
   endgenerate
endmodule

// File: tb/coh_line_ctrl_bench.sv
`timescale 1ns/1ps
module coh_line_ctrl_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       req_vld[2], rsp_vld[2], rsp_sh[2], snp_vld[2], csel[2];
   logic [3:0] req_cmd[2], rsp_cmd[2], snp_cmd[2], ccmd[2], bcmd_o[2];
   logic [2:0] cst[2], st_o[2];
   logic       bvld_o[2], sup_o[2], shr_o[2], err_o[2];
   logic [3:0] cnt_o[2];

   int checks = 0;
   int errors = 0;

   coh_line_ctrl #(.HAS_OWNED(1'b1), .HAS_EXCL(1'b1), .USE_UPG(1'b1), .CNT_W(4)) u_coh_line_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_vld(req_vld[0]), .req_cmd(req_cmd[0]),
      .rsp_vld(rsp_vld[0]), .rsp_cmd(rsp_cmd[0]), .rsp_shared(rsp_sh[0]),
      .snp_vld(snp_vld[0]), .snp_cmd(snp_cmd[0]),
      .line_state(st_o[0]), .bus_cmd_vld(bvld_o[0]), .bus_cmd(bcmd_o[0]),
      .snp_supply(sup_o[0]), .snp_assert_shared(shr_o[0]), .proto_err(err_o[0]),
      .cnt_sel_snp(csel[0]), .cnt_state(cst[0]), .cnt_cmd(ccmd[0]), .cnt_data(cnt_o[0]));

   coh_line_ctrl #(.HAS_OWNED(1'b0), .HAS_EXCL(1'b0), .USE_UPG(1'b0), .CNT_W(4)) u_coh_line_ctrl_min (
      .clk(clk), .rst_n(rst_n),
      .req_vld(req_vld[1]), .req_cmd(req_cmd[1]),
      .rsp_vld(rsp_vld[1]), .rsp_cmd(rsp_cmd[1]), .rsp_shared(rsp_sh[1]),
      .snp_vld(snp_vld[1]), .snp_cmd(snp_cmd[1]),
      .line_state(st_o[1]), .bus_cmd_vld(bvld_o[1]), .bus_cmd(bcmd_o[1]),
      .snp_supply(sup_o[1]), .snp_assert_shared(shr_o[1]), .proto_err(err_o[1]),
      .cnt_sel_snp(csel[1]), .cnt_state(cst[1]), .cnt_cmd(ccmd[1]), .cnt_data(cnt_o[1]));

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Expected behaviour from the requirements; k=0 full config, k=1 minimal.
   // Returns {ok, nst[2:0], bvld, bcmd[3:0], sup, shr}.
   function automatic logic [10:0] model(int k, int p, int s, int c, bit sh);
      bit ho = (k == 0), he = (k == 0), up = (k == 0);
      bit ok = 0, bv = 0, su = 0, ash = 0;
      int ns = s, bc = 0;
      int wsc = up ? 6 : 5;
      int wsr = up ? 11 : 10;
      bit kill = (c == 7 || c == 8);
      if (p == 0) begin
         if (c == 4) begin ok = 1; bv = 1; bc = 4; end
         else if (s == 0 && (c == 0 || c == 2 || c == 3)) begin ok = 1; bv = 1; bc = 0; end
         else if (s == 0 && c == 1) begin ok = 1; bv = 1; bc = 5; end
         else if ((s == 1 || (s == 2 && ho)) && c == 1) begin ok = 1; bv = 1; bc = wsc; end
      end else if (p == 1) begin
         if (s == 0 && c == 9) begin ok = 1; ns = (he && !sh) ? 3 : 1; end
         else if (s == 0 && c == 10) begin ok = 1; ns = 4; end
         else if ((s == 1 || (s == 2 && ho)) && c == wsr) begin ok = 1; ns = 4; end
      end else begin
         case (s)
            0: if (c == 0 || c == 5 || (c == 6 && up) || kill) ok = 1;
            1: if (c == 0) begin ok = 1; ash = he; end
               else if (c == 5 || (c == 6 && up) || kill) begin ok = 1; ns = 0; end
            4: if (c == 5) begin ok = 1; su = 1; ns = 0; end
               else if (c == 0) begin ok = 1; su = 1; ns = ho ? 2 : 1; end
               else if (kill) begin ok = 1; ns = 0; end
            3: if (he && c == 0) begin ok = 1; ash = 1; ns = 1; end
               else if (he && (c == 5 || kill)) begin ok = 1; ns = 0; end
            2: if (ho && c == 0) begin ok = 1; su = 1; end
               else if (ho && c == 5) begin ok = 1; su = 1; ns = 0; end
               else if (ho && (c == 6 || kill)) begin ok = 1; ns = 0; end
            default: ;
         endcase
      end
      return {ok, 3'(ns), bv, 4'(bc), su, ash};
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic pulse(int k, int p, int c, bit sh);
      @(negedge clk);
      if (p == 0) begin req_vld[k] = 1'b1; req_cmd[k] = 4'(c); end
      else if (p == 1) begin rsp_vld[k] = 1'b1; rsp_cmd[k] = 4'(c); rsp_sh[k] = sh; end
      else begin snp_vld[k] = 1'b1; snp_cmd[k] = 4'(c); end
      @(negedge clk);
      req_vld[k] = 1'b0; rsp_vld[k] = 1'b0; snp_vld[k] = 1'b0; rsp_sh[k] = 1'b0;
   endtask

   task automatic goto_state(int k, int s);
      do_reset();
      case (s)
         1: pulse(k, 1, 9, 1'b1);
         3: pulse(k, 1, 9, 1'b0);
         4: pulse(k, 1, 10, 1'b0);
         2: begin pulse(k, 1, 10, 1'b0); pulse(k, 2, 0, 1'b0); end
         default: ;
      endcase
   endtask

   function automatic int obs(int k);
      return {err_o[k], st_o[k], bvld_o[k], (bvld_o[k] ? bcmd_o[k] : 4'd0), sup_o[k], shr_o[k]};
   endfunction

   task automatic rd_cnt(int k, bit snp, int s, int c, output int v);
      csel[k] = snp; cst[k] = 3'(s); ccmd[k] = 4'(c);
      #1;
      v = int'(cnt_o[k]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int v;
      for (int k = 0; k < 2; k++) begin
         req_vld[k] = 0; rsp_vld[k] = 0; snp_vld[k] = 0; rsp_sh[k] = 0;
         req_cmd[k] = 0; rsp_cmd[k] = 0; snp_cmd[k] = 0;
         csel[k] = 0; cst[k] = 0; ccmd[k] = 0;
      end
      do_reset();

      // R1 reset state
      for (int k = 0; k < 2; k++) begin
         check("R1 reset outputs", obs(k), 0);
         rd_cnt(k, 1'b0, 0, 4, v);
         check("R1 reset counter", v, 0);
      end

      // Sweep: every reachable state, every command, every path (R2..R9, R12)
      for (int k = 0; k < 2; k++) begin
         for (int s = 0; s < 5; s++) begin
            if (k == 1 && (s == 2 || s == 3)) continue;
            for (int p = 0; p < 3; p++) begin
               for (int c = 0; c < 16; c++) begin
                  for (int sh = 0; sh < ((p == 1) ? 2 : 1); sh++) begin
                     logic [10:0] m;
                     int exp;
                     string tag;
                     goto_state(k, s);
                     check("R1 setup state", int'(st_o[k]), s);
                     pulse(k, p, c, sh[0]);
                     m = model(k, p, s, c, sh[0]);
                     exp = {~m[10], (m[10] ? m[9:7] : 3'(s)), m[6], m[5:2], m[1], m[0]};
                     if (!m[10]) tag = "R9 illegal pair";
                     else if (p == 0) tag = (c == 4) ? "R4 writeback" : ((s == 0) ? "R2 request" : "R3 write-to-shared");
                     else if (p == 1) tag = "R5 response";
                     else if (s <= 1) tag = "R6 snoop I/S";
                     else if (s == 4) tag = "R7 snoop M";
                     else tag = "R8 snoop E/O";
                     if (k == 1 && m[10]) tag = {tag, " R12 minimal"};
                     check(tag, obs(k), exp);
                  end
               end
            end
         end
      end

      // R12 explicit: minimal config, clean read fill and snooped read on M
      goto_state(1, 0);
      pulse(1, 1, 9, 1'b0);
      check("R12 fill lands Shared", int'(st_o[1]), 1);
      goto_state(1, 4);
      pulse(1, 2, 0, 1'b0);
      check("R12 M read snoop lands Shared", int'(st_o[1]), 1);

      // R10 priority: snoop beats response and request
      do_reset();
      @(negedge clk);
      snp_vld[0] = 1; snp_cmd[0] = 4'd0;
      rsp_vld[0] = 1; rsp_cmd[0] = 4'd10;
      req_vld[0] = 1; req_cmd[0] = 4'd1;
      @(negedge clk);
      snp_vld[0] = 0; rsp_vld[0] = 0; req_vld[0] = 0;
      check("R10 snoop wins", obs(0), 0);
      rd_cnt(0, 1'b1, 0, 0, v);
      check("R10 snoop counted", v, 1);
      rd_cnt(0, 1'b0, 0, 1, v);
      check("R10 losing request not counted", v, 0);
      // response beats request
      @(negedge clk);
      rsp_vld[0] = 1; rsp_cmd[0] = 4'd9; rsp_sh[0] = 0;
      req_vld[0] = 1; req_cmd[0] = 4'd1;
      @(negedge clk);
      rsp_vld[0] = 0; req_vld[0] = 0;
      check("R10 response wins state", int'(st_o[0]), 3);
      check("R10 request dropped", int'(bvld_o[0]), 0);
      rd_cnt(0, 1'b0, 0, 1, v);
      check("R10 dropped request not counted", v, 0);

      // R11 counters: saturation and bank separation
      do_reset();
      for (int i = 0; i < 20; i++) pulse(0, 0, 4, 1'b0);
      rd_cnt(0, 1'b0, 0, 4, v);
      check("R11 request counter saturates", v, 15);
      rd_cnt(0, 1'b1, 0, 4, v);
      check("R11 snoop bank untouched", v, 0);
      for (int i = 0; i < 3; i++) pulse(0, 2, 0, 1'b0);
      rd_cnt(0, 1'b1, 0, 0, v);
      check("R11 snoop counter", v, 3);
      pulse(0, 0, 9, 1'b0);
      rd_cnt(0, 1'b0, 0, 9, v);
      check("R11 illegal request counted", v, 1);
      rd_cnt(0, 1'b0, 1, 4, v);
      check("R11 other state counter zero", v, 0);
      pulse(0, 1, 10, 1'b0);
      pulse(0, 0, 4, 1'b0);
      rd_cnt(0, 1'b0, 4, 4, v);
      check("R11 counted at Modified", v, 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule